// File: doc/BRIEF.md
# Transmit Buffer Cancellation Controller

This block tracks which transmit buffers of a multi-buffer message controller hold a queued send request. It lets the host withdraw those requests one buffer at a time. The host sees two vectors with one bit per buffer. The request vector marks buffers waiting to be sent, and the cancel vector marks withdrawals that have not finished yet. A host write to the cancel vector can name any set of buffers. Each named bit that is eligible is latched as an outstanding cancellation.

An outstanding cancellation does not always finish at once. The transmit scheduler reports when it is in the middle of choosing the next buffer, and cancellations wait until that round ends. The bus transfer layer reports which buffer it is currently sending. A cancellation aimed at that buffer waits for the end-of-transmission pulse, whatever the outcome of the frame. When a cancellation completes, the cancel bit and the request bit of that buffer drop on the same clock edge. At that edge a sticky completion flag is also set. The flag drives an interrupt only while both the cancel-specific enable and the global enable are high.

The host can learn that a cancellation has finished in two ways: it can poll the cancel vector until the bit is gone, or it can wait for the interrupt. All pins are plain control and status levels or strobes. The block has no streaming data path, so it carries no valid/ready handshake.

Top module: `tx_cancel_ctrl`

## Requirements
- R1: A cancel write latches a bit only where that buffer's request bit is 1 and its cancel bit is 0. Every other bit of the write is ignored, and neither vector changes because of it.
- R2: One cancel write may name several buffers, and every eligible named buffer becomes outstanding on the same edge.
- R3: An outstanding cancellation whose buffer index equals `lock_idx` while `lock_valid` is 1 is held until a cycle in which `tx_end` is 1. It completes on that edge, whether the frame succeeded or failed.
- R4: While `sched_busy` is 1, no outstanding cancellation completes. Held cancellations complete on the first edge at which `sched_busy` is 0.
- R5: An outstanding cancellation that is not held completes on the first edge after it became visible. The cancel bit is therefore readable for exactly one cycle.
- R6: On completion, the buffer's cancel bit and its request bit are both cleared on the same edge.
- R7: The edge that completes any cancellation sets `cancel_done` to 1.
- R8: `irq` is 1 exactly when `cancel_done`, `irq_en_cancel` and `irq_en_global` are all 1. The interrupt output is not registered.
- R9: All cancellations released in the same cycle complete together on one edge. That edge sets the single `cancel_done` flag.
- R10: `cancel_done` stays set until the host pulses `flag_w1c` (write-one-to-clear). If a completion and a clear fall on the same edge, the flag ends up set.
- R11: A request write ORs `req_set_mask` into the request vector. If a buffer's request bit is written on the same edge that its cancellation completes, the bit stays 1.
- R12: The buffer count is the parameter `NUM_BUF`, 32 by default. Under reset, both vectors and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set_we | input | 1 | Strobe for a host write to the request vector |
| req_set_mask | input | NUM_BUF | Buffers whose request bit is to be set |
| cancel_we | input | 1 | Strobe for a host write to the cancel vector |
| cancel_mask | input | NUM_BUF | Buffers to cancel |
| sched_busy | input | 1 | A scheduling round is in progress |
| lock_valid | input | 1 | The transfer layer is sending from a buffer |
| lock_idx | input | $clog2(NUM_BUF) | Index of the buffer being sent |
| tx_end | input | 1 | One-cycle pulse at the end of the current transmission, whatever its outcome |
| flag_w1c | input | 1 | Host write of 1 that clears `cancel_done` |
| irq_en_cancel | input | 1 | Interrupt enable for cancel completion |
| irq_en_global | input | 1 | Global interrupt enable |
| req_pend | output | NUM_BUF | Request vector |
| cancel_pend | output | NUM_BUF | Outstanding cancel vector |
| cancel_done | output | 1 | Sticky cancel-complete status flag |
| irq | output | 1 | Interrupt request |

## Verification
Cancellation is exercised with four kinds of input pattern. A multi-bit write on an idle system shows that requests complete in one cycle and leave unrelated request bits alone. A write to buffers with no request shows that ineligible bits are filtered out. A write during a long scheduling round shows that completion is held off and then released as a batch, including cancel bits latched in different cycles. A write aimed at the buffer being sent, in the top index position, alongside an unlocked buffer shows that the lock holds only its own buffer until `tx_end`. Same-edge collisions are also driven: a request write or a flag clear on the edge that completes a cancellation. These show which side wins.

// File: rtl/txc_pkg.sv
package txc_pkg;

  // Index width for a buffer count; never below one bit.
  function automatic int unsigned idx_width(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

  // Stages a cancellation can be in, as seen per buffer.
  typedef enum logic [1:0] {
    CX_IDLE    = 2'd0,
    CX_HELD    = 2'd1,
    CX_RELEASE = 2'd2
  } cx_stage_e;

endpackage

// File: rtl/txc_accept.sv
module txc_accept #(
  parameter int unsigned NUM_BUF = 32
) (
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wr_mask,
  input  logic [NUM_BUF-1:0] req_pend,
  input  logic [NUM_BUF-1:0] cancel_pend,
  output logic [NUM_BUF-1:0] accept_mask
);

  // Eligible only with a live request and no cancellation already outstanding.
  always_comb begin
    accept_mask = '0;
    if (wr_en) begin
      accept_mask = wr_mask & req_pend & ~cancel_pend;
    end
  end

endmodule

// File: rtl/txc_defer.sv
module txc_defer
  import txc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IW     = idx_width(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0] cancel_pend,
  input  logic               sched_busy,
  input  logic               lock_valid,
  input  logic [IW-1:0]      lock_idx,
  input  logic               tx_end,
  output logic [NUM_BUF-1:0] release_mask,
  output logic               any_release
);

  cx_stage_e stage [NUM_BUF];

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    localparam logic [IW-1:0] MY_IDX = IW'(i);
    logic locked_here;
    logic held;

    // The lock holds this buffer until the transmission-end pulse arrives.
    assign locked_here = lock_valid && (lock_idx == MY_IDX) && !tx_end;
    assign held        = sched_busy || locked_here;

    always_comb begin
      if (!cancel_pend[i]) begin
        stage[i] = CX_IDLE;
      end else if (held) begin
        stage[i] = CX_HELD;
      end else begin
        stage[i] = CX_RELEASE;
      end
    end

    assign release_mask[i] = (stage[i] == CX_RELEASE);
  end

  assign any_release = |release_mask;

endmodule

// File: rtl/txc_status.sv
module txc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic any_release,
  input  logic flag_w1c,
  input  logic irq_en_cancel,
  input  logic irq_en_global,
  output logic cancel_done,
  output logic irq
);

  // A new completion beats a host clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cancel_done <= 1'b0;
    end else if (any_release) begin
      cancel_done <= 1'b1;
    end else if (flag_w1c) begin
      cancel_done <= 1'b0;
    end
  end

  assign irq = cancel_done && irq_en_cancel && irq_en_global;

endmodule

// File: rtl/tx_cancel_ctrl.sv
module tx_cancel_ctrl
  import txc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IW     = idx_width(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_set_we,
  input  logic [NUM_BUF-1:0] req_set_mask,
  input  logic               cancel_we,
  input  logic [NUM_BUF-1:0] cancel_mask,
  input  logic               sched_busy,
  input  logic               lock_valid,
  input  logic [IW-1:0]      lock_idx,
  input  logic               tx_end,
  input  logic               flag_w1c,
  input  logic               irq_en_cancel,
  input  logic               irq_en_global,
  output logic [NUM_BUF-1:0] req_pend,
  output logic [NUM_BUF-1:0] cancel_pend,
  output logic               cancel_done,
  output logic               irq
);

  logic [NUM_BUF-1:0] accept_mask;
  logic [NUM_BUF-1:0] release_mask;
  logic [NUM_BUF-1:0] req_add;
  logic               any_release;

  txc_accept #(.NUM_BUF(NUM_BUF)) u_accept (
    .wr_en       (cancel_we),
    .wr_mask     (cancel_mask),
    .req_pend    (req_pend),
    .cancel_pend (cancel_pend),
    .accept_mask (accept_mask)
  );

  txc_defer #(.NUM_BUF(NUM_BUF)) u_defer (
    .cancel_pend  (cancel_pend),
    .sched_busy   (sched_busy),
    .lock_valid   (lock_valid),
    .lock_idx     (lock_idx),
    .tx_end       (tx_end),
    .release_mask (release_mask),
    .any_release  (any_release)
  );

  txc_status u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .any_release   (any_release),
    .flag_w1c      (flag_w1c),
    .irq_en_cancel (irq_en_cancel),
    .irq_en_global (irq_en_global),
    .cancel_done   (cancel_done),
    .irq           (irq)
  );

  assign req_add = req_set_we ? req_set_mask : '0;

  // Request bits: a fresh host write outranks a completing cancellation.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pend <= '0;
    end else begin
      req_pend <= (req_pend & ~release_mask) | req_add;
    end
  end

  // Outstanding cancels: released bits drop, newly accepted bits appear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cancel_pend <= '0;
    end else begin
      cancel_pend <= (cancel_pend & ~release_mask) | accept_mask;
    end
  end

endmodule

// File: rtl/tx_cancel_ctrl_checker.sv
module tx_cancel_ctrl_checker
  import txc_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  localparam int unsigned IW     = idx_width(NUM_BUF)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_set_we,
  input logic               sched_busy,
  input logic               lock_valid,
  input logic [IW-1:0]      lock_idx,
  input logic               tx_end,
  input logic               flag_w1c,
  input logic               irq_en_cancel,
  input logic               irq_en_global,
  input logic [NUM_BUF-1:0] req_pend,
  input logic [NUM_BUF-1:0] cancel_pend,
  input logic               cancel_done,
  input logic               irq
);

  // R1: a cancel bit only appears for a buffer that had a request.
  assert_cancel_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cancel_pend & ~$past(cancel_pend) & ~$past(req_pend)) == '0));

  // R3: the locked buffer keeps its cancel bit until the end pulse.
  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_valid && !tx_end && cancel_pend[lock_idx]) |=> cancel_pend[$past(lock_idx)]);

  // R4: a scheduling round keeps every outstanding cancel bit.
  assert_sched_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sched_busy |=> ((cancel_pend & $past(cancel_pend)) == $past(cancel_pend)));

  // R6: a dropped cancel bit takes its request bit with it.
  assert_both_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_set_we) |-> ((($past(cancel_pend) & ~cancel_pend) & req_pend) == '0));

  // R7: any completion leaves the flag set.
  assert_flag_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(cancel_pend) & ~cancel_pend)) |-> cancel_done);

  // R8: interrupt needs the flag and both enables.
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cancel_done && irq_en_cancel && irq_en_global));

  // R10: the flag is sticky without a host clear.
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_done && !flag_w1c) |=> cancel_done);

endmodule

bind tx_cancel_ctrl tx_cancel_ctrl_checker #(.NUM_BUF(NUM_BUF)) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_set_we    (req_set_we),
  .sched_busy    (sched_busy),
  .lock_valid    (lock_valid),
  .lock_idx      (lock_idx),
  .tx_end        (tx_end),
  .flag_w1c      (flag_w1c),
  .irq_en_cancel (irq_en_cancel),
  .irq_en_global (irq_en_global),
  .req_pend      (req_pend),
  .cancel_pend   (cancel_pend),
  .cancel_done   (cancel_done),
  .irq           (irq)
);

// File: tb/tx_cancel_ctrl_test.sv
module tx_cancel_ctrl_test;

  localparam int unsigned N  = 32;
  localparam int unsigned IW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_set_we = 1'b0;
  logic [N-1:0]  req_set_mask = '0;
  logic          cancel_we = 1'b0;
  logic [N-1:0]  cancel_mask = '0;
  logic          sched_busy = 1'b0;
  logic          lock_valid = 1'b0;
  logic [IW-1:0] lock_idx = '0;
  logic          tx_end = 1'b0;
  logic          flag_w1c = 1'b0;
  logic          irq_en_cancel = 1'b0;
  logic          irq_en_global = 1'b0;
  logic [N-1:0]  req_pend;
  logic [N-1:0]  cancel_pend;
  logic          cancel_done;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tx_cancel_ctrl #(.NUM_BUF(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_set_we(req_set_we), .req_set_mask(req_set_mask),
    .cancel_we(cancel_we), .cancel_mask(cancel_mask),
    .sched_busy(sched_busy), .lock_valid(lock_valid), .lock_idx(lock_idx),
    .tx_end(tx_end), .flag_w1c(flag_w1c),
    .irq_en_cancel(irq_en_cancel), .irq_en_global(irq_en_global),
    .req_pend(req_pend), .cancel_pend(cancel_pend),
    .cancel_done(cancel_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Falling edge: drop all strobes; caller then drives new values.
  task automatic nedge();
    @(negedge clk);
    req_set_we = 1'b0;
    cancel_we  = 1'b0;
    flag_w1c   = 1'b0;
    tx_end     = 1'b0;
  endtask

  // Just after the rising edge, where registered outputs are settled.
  task automatic pedge();
    @(posedge clk);
    #1;
  endtask

  task automatic set_req(input logic [N-1:0] m);
    nedge(); req_set_we = 1'b1; req_set_mask = m; pedge();
  endtask

  task automatic clear_flag();
    nedge(); flag_w1c = 1'b1; pedge();
  endtask

  task automatic t_reset();
    #1;
    chk("R12 reset req", req_pend, '0);
    chk("R12 reset cancel", cancel_pend, '0);
    chk("R12 reset flag", N'(cancel_done), '0);
    chk("R12 reset irq", N'(irq), '0);
    nedge(); rst_n = 1'b1; pedge();
  endtask

  task automatic t_immediate();
    set_req(32'h0000_000F);
    chk("R11 req set", req_pend, 32'h0000_000F);
    nedge(); cancel_we = 1'b1; cancel_mask = 32'h0000_0005; pedge();
    chk("R2 multi cancel latched", cancel_pend, 32'h0000_0005);
    chk("R5 flag not yet", N'(cancel_done), '0);
    nedge(); pedge();
    chk("R5 cancel done next edge", cancel_pend, '0);
    chk("R6 req cleared", req_pend, 32'h0000_000A);
    chk("R7 flag set", N'(cancel_done), 1);
    chk("R8 irq off no enables", N'(irq), '0);
    nedge(); irq_en_cancel = 1'b1; #1;
    chk("R8 irq off global low", N'(irq), '0);
    irq_en_global = 1'b1; #1;
    chk("R8 irq on", N'(irq), 1);
    clear_flag();
    chk("R10 flag cleared", N'(cancel_done), '0);
    chk("R8 irq drops", N'(irq), '0);
  endtask

  task automatic t_ignored();
    nedge(); cancel_we = 1'b1; cancel_mask = 32'h0000_0015; pedge();
    chk("R1 ignored cancel", cancel_pend, '0);
    chk("R1 req unchanged", req_pend, 32'h0000_000A);
    nedge(); pedge();
    chk("R1 no flag", N'(cancel_done), '0);
  endtask

  task automatic t_sched();
    nedge(); sched_busy = 1'b1; cancel_we = 1'b1; cancel_mask = 32'h0000_0002; pedge();
    chk("R4 latched", cancel_pend, 32'h0000_0002);
    nedge(); pedge();
    nedge(); pedge();
    chk("R4 held cancel", cancel_pend, 32'h0000_0002);
    chk("R4 held req", req_pend, 32'h0000_000A);
    chk("R4 held no flag", N'(cancel_done), '0);
    nedge(); cancel_we = 1'b1; cancel_mask = 32'h0000_0002; pedge();
    chk("R1 repeat cancel", cancel_pend, 32'h0000_0002);
    nedge(); sched_busy = 1'b0; pedge();
    chk("R4 released", cancel_pend, '0);
    chk("R6 req after round", req_pend, 32'h0000_0008);
    chk("R7 flag after round", N'(cancel_done), 1);
    clear_flag();
  endtask

  task automatic t_lock();
    set_req(32'h8000_0080);
    nedge(); lock_valid = 1'b1; lock_idx = 5'd31;
    cancel_we = 1'b1; cancel_mask = 32'h8000_0080; pedge();
    chk("R2 two latched", cancel_pend, 32'h8000_0080);
    nedge(); pedge();
    chk("R3 locked stays", cancel_pend, 32'h8000_0000);
    chk("R6 unlocked req gone", req_pend, 32'h8000_0008);
    chk("R7 flag from unlocked", N'(cancel_done), 1);
    clear_flag();
    nedge(); pedge();
    chk("R3 still held", cancel_pend, 32'h8000_0000);
    chk("R10 flag stays clear", N'(cancel_done), '0);
    nedge(); tx_end = 1'b1; pedge();
    chk("R3 done at tx end", cancel_pend, '0);
    chk("R6 top req cleared", req_pend, 32'h0000_0008);
    chk("R7 flag at tx end", N'(cancel_done), 1);
    nedge(); lock_valid = 1'b0;
    clear_flag();
  endtask

  task automatic t_batch();
    set_req(32'h0000_0030);
    nedge(); sched_busy = 1'b1; cancel_we = 1'b1; cancel_mask = 32'h0000_0010; pedge();
    nedge(); cancel_we = 1'b1; cancel_mask = 32'h0000_0020; pedge();
    chk("R9 both held", cancel_pend, 32'h0000_0030);
    chk("R9 no flag yet", N'(cancel_done), '0);
    nedge(); sched_busy = 1'b0; pedge();
    chk("R9 released together", cancel_pend, '0);
    chk("R9 req cleared together", req_pend, 32'h0000_0008);
    chk("R9 flag", N'(cancel_done), 1);
    clear_flag();
  endtask

  task automatic t_collide();
    set_req(32'h0000_0001);
    nedge(); cancel_we = 1'b1; cancel_mask = 32'h0000_0001; pedge();
    nedge(); flag_w1c = 1'b1; req_set_we = 1'b1; req_set_mask = 32'h0000_0001; pedge();
    chk("R11 set beats clear", req_pend, 32'h0000_0009);
    chk("R6 cancel cleared", cancel_pend, '0);
    chk("R10 set beats w1c", N'(cancel_done), 1);
    clear_flag();
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_ignored();
    t_sched();
    t_lock();
    t_batch();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule